// File: doc/BRIEF.md
# DRAM Traffic Event Counter Unit

This block counts traffic events reported by a DRAM controller. Eight 32-bit counters are each wired to one fixed event input: write data volume, read data volume, write commands, read commands, precharge commands, activate commands, rank switches and read/write direction switches. The counter index is also the event code, so there is no event-select logic. A counter advances only when three things are high in the same cycle: the global enable, its own enable bit and its event pulse.

Software reaches the block through a single-cycle register port. Through that port it sets the global and per-counter enables, preloads or reads any counter, and manages the overflow interrupt. When a counter wraps from all ones to zero, its status bit is set. The interrupt output is high while any status bit is set and not masked. Status bits are cleared by writing ones to a separate clear register.

The counter registers sit at irregular offsets, so the address decoder compares against a fixed table rather than using index arithmetic.

Top module: `memEvtCounters`

## Requirements
- R1: A counter increments by exactly one in a cycle only when the global enable, its own enable bit and its event pulse input are all high in that cycle. Otherwise it holds its value, unless software writes it.
- R2: Counters 0 to 7 are read and written at byte offsets 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC and 0x3D0, in that order.
- R3: A register write to a counter loads all 32 bits of write data. If that counter would also increment in the same cycle, the write wins.
- R4: An increment that wraps a counter from 0xFFFFFFFF to 0 sets that counter's status bit, whatever the mask holds.
- R5: `irqOut` is high exactly when some status bit is set and its mask bit is 0.
- R6: Writing ones to the clear register at 0x6D0 clears the matching status bits, and the clear register reads as zero. If a wrap and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: After reset, the mask register reads 0xFF, every other register and counter reads zero, and `irqOut` is low.
- R8: Reads of unmapped offsets return zero, and writes to them change no register. The status register at 0x6CC ignores writes.
- R9: Bit 1 of the control register at 0x010 is the global enable. Bit i of the enable register at 0x6C0 enables counter i. Bit i of the mask register at 0x6C8 masks counter i. The status register at 0x6CC shows bit i for counter i. All other bits read as zero.
- R10: Read data is registered. `regRdata` takes the value of the addressed register as it was before the clock edge at which `regRe` is sampled, and it is valid in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte offset of the register access |
| regWe | input | 1 | Write strobe, single cycle |
| regWdata | input | 32 | Write data |
| regRe | input | 1 | Read strobe, single cycle |
| regRdata | output | 32 | Registered read data |
| evtPulse | input | 8 | Event pulses; bit i feeds counter i |
| irqOut | output | 1 | Level overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle and collide. The first pair is a software write to a counter and that counter's own increment. The second pair is a counter wrap and a clear-register write aimed at the same status bit. Directed cases provoke both collisions by driving the write with the event pulse high on the same edge, including a wrap from a preloaded 0xFFFFFFFF under a simultaneous clear. The results are judged by reading back the counter and the status register and by watching `irqOut`. Random traffic then mixes event pulses with writes that preload values near the wrap point, so both collisions keep recurring, and a bench model decides the outcome.

// File: rtl/memEvtPkg.sv
package memEvtPkg;
  localparam int NUM_CNT = 8;
  localparam int CNT_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int GLB_BIT = 1;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_CNTEN = 12'h6C0;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h6C8;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h6CC;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h6D0;

  // Irregular counter placement; decode depends on this exact table.
  function automatic logic [ADDR_W-1:0] cntOffset(input int idx);
    case (idx)
      0:       return 12'h380;
      1:       return 12'h384;
      2:       return 12'h388;
      3:       return 12'h38C;
      4:       return 12'h3C0;
      5:       return 12'h3C4;
      6:       return 12'h3CC;
      default: return 12'h3D0;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_CNT-1:0] wrEn;
    logic [NUM_CNT-1:0] incEn;
    logic [CNT_W-1:0]   wrData;
  } cntStrobeT;
endpackage

// File: rtl/memEvtCntBank.sv
module memEvtCntBank
  import memEvtPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  cntStrobeT                     strobe,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0]            wrapPulse
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cntQ <= '0;
      else if (strobe.wrEn[i])  cntQ <= strobe.wrData;
      else if (strobe.incEn[i]) cntQ <= cntQ + 1'b1;
    end

    // A wrap only counts when the increment is not overridden by a write.
    assign wrapPulse[i] = strobe.incEn[i] & ~strobe.wrEn[i] & (&cntQ);
    assign cntVal[i]    = cntQ;
  end
endmodule

// File: rtl/memEvtCtrl.sv
module memEvtCtrl
  import memEvtPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWe,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic                          regRe,
  input  logic [NUM_CNT-1:0]            evtPulse,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]            wrapPulse,
  output cntStrobeT                     strobe,
  output logic [DATA_W-1:0]             regRdata,
  output logic                          irqOut,
  output logic [NUM_CNT-1:0]            statusQ,
  output logic [NUM_CNT-1:0]            maskQ,
  output logic                          glbEn
);
  logic [NUM_CNT-1:0] cntHit;
  logic [NUM_CNT-1:0] enQ;
  logic [NUM_CNT-1:0] clrVec;
  logic [DATA_W-1:0]  rdNext;
  logic               wrCtrl, wrEn, wrMask, wrClr;

  for (genvar i = 0; i < NUM_CNT; i++) begin : gHit
    assign cntHit[i] = (regAddr == cntOffset(i));
  end

  assign wrCtrl = regWe && (regAddr == OFF_CTRL);
  assign wrEn   = regWe && (regAddr == OFF_CNTEN);
  assign wrMask = regWe && (regAddr == OFF_MASK);
  assign wrClr  = regWe && (regAddr == OFF_CLR);

  assign strobe.wrEn   = {NUM_CNT{regWe}} & cntHit;
  assign strobe.incEn  = {NUM_CNT{glbEn}} & enQ & evtPulse;
  assign strobe.wrData = regWdata[CNT_W-1:0];

  assign clrVec = wrClr ? regWdata[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbEn   <= 1'b0;
      enQ     <= '0;
      maskQ   <= '1;
      statusQ <= '0;
    end else begin
      if (wrCtrl) glbEn <= regWdata[GLB_BIT];
      if (wrEn)   enQ   <= regWdata[NUM_CNT-1:0];
      if (wrMask) maskQ <= regWdata[NUM_CNT-1:0];
      // Set has priority over clear.
      statusQ <= (statusQ & ~clrVec) | wrapPulse;
    end
  end

  always_comb begin
    rdNext = '0;
    case (regAddr)
      OFF_CTRL:  rdNext[GLB_BIT]     = glbEn;
      OFF_CNTEN: rdNext[NUM_CNT-1:0] = enQ;
      OFF_MASK:  rdNext[NUM_CNT-1:0] = maskQ;
      OFF_STAT:  rdNext[NUM_CNT-1:0] = statusQ;
      default:   rdNext = '0;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (cntHit[k]) rdNext = DATA_W'(cntVal[k]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRdata <= '0;
    else if (regRe) regRdata <= rdNext;
  end

  assign irqOut = |(statusQ & ~maskQ);
endmodule

// File: rtl/memEvtCounters.sv
module memEvtCounters
  import memEvtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  input  logic              regRe,
  output logic [31:0]       regRdata,
  input  logic [7:0]        evtPulse,
  output logic              irqOut
);
  cntStrobeT                     strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVec;
  logic [NUM_CNT-1:0]            wrapVec;
  logic [NUM_CNT-1:0]            statusVec;
  logic [NUM_CNT-1:0]            maskVec;
  logic                          glbEn;

  memEvtCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRe     (regRe),
    .evtPulse  (evtPulse),
    .cntVal    (cntVec),
    .wrapPulse (wrapVec),
    .strobe    (strobe),
    .regRdata  (regRdata),
    .irqOut    (irqOut),
    .statusQ   (statusVec),
    .maskQ     (maskVec),
    .glbEn     (glbEn)
  );

  memEvtCntBank u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntVal    (cntVec),
    .wrapPulse (wrapVec)
  );
endmodule

// File: rtl/memEvtCheck.sv
module memEvtCheck
  import memEvtPkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             regAddr,
  input logic                          regWe,
  input logic [DATA_W-1:0]             regWdata,
  input logic                          irqOut,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_CNT-1:0]            wrapVec,
  input logic [NUM_CNT-1:0]            statusVec,
  input logic [NUM_CNT-1:0]            maskVec,
  input logic                          glbEn
);
  logic [NUM_CNT-1:0] clrW;
  assign clrW = (regWe && regAddr == OFF_CLR) ? regWdata[NUM_CNT-1:0] : '0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : gStep
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      !regWe |=> (cntVec[i] == $past(cntVec[i]) || cntVec[i] == $past(cntVec[i]) + 1'b1)); // R1
  end

  AST_GLB_OFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!glbEn && !regWe) |=> $stable(cntVec)); // R1

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|wrapVec) |=> ((statusVec & $past(wrapVec)) == $past(wrapVec))); // R4

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |-> !irqOut); // R5

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & $past(statusVec & ~clrW)) == $past(statusVec & ~clrW))); // R6
endmodule

bind memEvtCounters memEvtCheck u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWe     (regWe),
  .regWdata  (regWdata),
  .irqOut    (irqOut),
  .cntVec    (cntVec),
  .wrapVec   (wrapVec),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .glbEn     (glbEn)
);

// File: tb/memEvtCounters_bench.sv
`timescale 1ns/1ps
module memEvtCounters_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic        regRe = 1'b0;
  logic [31:0] regRdata;
  logic [7:0]  evtPulse = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memEvtCounters u_memEvtCounters (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRe(regRe), .regRdata(regRdata),
    .evtPulse(evtPulse), .irqOut(irqOut)
  );

  // Bench model
  logic [31:0] mCnt [8];
  logic        mGlb;
  logic [7:0]  mEn, mMask, mStat;

  function automatic logic [11:0] offOf(input int i);
    case (i)
      0: return 12'h380; 1: return 12'h384; 2: return 12'h388; 3: return 12'h38C;
      4: return 12'h3C0; 5: return 12'h3C4; 6: return 12'h3CC; default: return 12'h3D0;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    logic [31:0] v = '0;
    case (a)
      12'h010: v[1] = mGlb;
      12'h6C0: v[7:0] = mEn;
      12'h6C8: v[7:0] = mMask;
      12'h6CC: v[7:0] = mStat;
      default: v = '0;
    endcase
    for (int i = 0; i < 8; i++) if (a == offOf(i)) v = mCnt[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mCnt[i] = '0;
    mGlb = 0; mEn = '0; mMask = 8'hFF; mStat = '0;
  endtask

  task automatic modelUpdate(input logic we, input logic [11:0] a,
                             input logic [31:0] d, input logic [7:0] p);
    logic [7:0] wrapV = '0;
    logic [7:0] clr;
    for (int i = 0; i < 8; i++) begin
      if (we && a == offOf(i)) mCnt[i] = d;
      else if (mGlb && mEn[i] && p[i]) begin
        if (mCnt[i] == 32'hFFFF_FFFF) wrapV[i] = 1'b1;
        mCnt[i] = mCnt[i] + 1;
      end
    end
    clr = (we && a == 12'h6D0) ? d[7:0] : 8'h00;
    mStat = (mStat & ~clr) | wrapV;
    if (we && a == 12'h010) mGlb = d[1];
    if (we && a == 12'h6C0) mEn = d[7:0];
    if (we && a == 12'h6C8) mMask = d[7:0];
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, clock, check at next negedge.
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic re, input logic [7:0] p, input string req);
    logic [31:0] expRd;
    logic        expIrq;
    regWe = we; regAddr = a; regWdata = d; regRe = re; evtPulse = p;
    expRd = modelRead(a);
    @(posedge clk);
    modelUpdate(we, a, d, p);
    @(negedge clk);
    regWe = 0; regRe = 0; evtPulse = '0;
    if (re) chk(regRdata === expRd, req, regRdata, expRd);
    expIrq = |(mStat & ~mMask);
    chk(irqOut === expIrq, "R5 irq", {31'b0, irqOut}, {31'b0, expIrq});
  endtask

  task automatic rdLit(input logic [11:0] a, input logic [31:0] lit, input string req);
    step(0, a, '0, 1, '0, req);
    chk(regRdata === lit, req, regRdata, lit);
  endtask

  function automatic logic [11:0] addrPick(input int k);
    case (k)
      8: return 12'h010; 9: return 12'h6C0; 10: return 12'h6C8; 11: return 12'h6CC;
      12: return 12'h6D0; 13: return 12'h3C8; 14: return 12'h000; 15: return 12'h6C4;
      default: return offOf(k);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk(irqOut === 1'b0, "R7 irq", {31'b0, irqOut}, 0);
    rdLit(12'h6C8, 32'hFF, "R7 mask");
    rdLit(12'h010, 32'h0, "R7 ctrl");
    rdLit(12'h6C0, 32'h0, "R7 en");
    rdLit(12'h6CC, 32'h0, "R7 stat");
    for (int i = 0; i < 8; i++) rdLit(offOf(i), 32'h0, "R7 cnt");

    // R1: pulses with nothing enabled do not count
    step(0, 12'h0, 0, 0, 8'hFF, "R1");
    step(1, 12'h6C0, 32'h01, 0, 8'hFF, "R9 en");
    step(0, 12'h0, 0, 0, 8'hFF, "R1");
    rdLit(12'h380, 32'h0, "R1 global off");
    step(1, 12'h010, 32'h2, 0, 8'h00, "R9 ctrl");
    rdLit(12'h010, 32'h2, "R9 ctrl read");
    step(0, 12'h0, 0, 0, 8'hFF, "R1");
    step(0, 12'h0, 0, 0, 8'hFE, "R1");
    rdLit(12'h380, 32'h1, "R1 cnt0");
    rdLit(12'h384, 32'h0, "R1 cnt1 disabled");

    // R2 / R3: write priority over increment
    step(1, 12'h6C0, 32'hFF, 0, 0, "R9 en");
    step(1, 12'h388, 32'h1234, 0, 8'h04, "R3");
    rdLit(12'h388, 32'h1234, "R3 write wins");
    step(1, 12'h3CC, 32'hA5A5_0001, 0, 0, "R2");
    rdLit(12'h3CC, 32'hA5A5_0001, "R2 cnt6");

    // R4 / R5 / R6: wrap, mask, clear
    step(1, 12'h3C4, 32'hFFFF_FFFF, 0, 0, "R4");
    step(0, 12'h0, 0, 0, 8'h20, "R4");
    rdLit(12'h3C4, 32'h0, "R4 wrap value");
    rdLit(12'h6CC, 32'h20, "R4 status masked");
    chk(irqOut === 1'b0, "R5 masked", {31'b0, irqOut}, 0);
    step(1, 12'h6C8, 32'hDF, 0, 0, "R5");
    chk(irqOut === 1'b1, "R5 unmasked", {31'b0, irqOut}, 1);
    rdLit(12'h6D0, 32'h0, "R6 clr reads zero");
    step(1, 12'h6D0, 32'h20, 0, 0, "R6");
    rdLit(12'h6CC, 32'h0, "R6 cleared");
    chk(irqOut === 1'b0, "R6 irq drop", {31'b0, irqOut}, 0);
    step(1, 12'h3D0, 32'hFFFF_FFFF, 0, 0, "R6");
    step(1, 12'h6D0, 32'h80, 0, 8'h80, "R6");
    rdLit(12'h6CC, 32'h80, "R6 set wins");

    // R8: unmapped and status writes ignored
    step(1, 12'h3C8, 32'hDEAD_BEEF, 0, 0, "R8");
    rdLit(12'h3C8, 32'h0, "R8 unmapped read");
    step(1, 12'h6CC, 32'h00, 0, 0, "R8");
    rdLit(12'h6CC, 32'h80, "R8 status write ignored");
    rdLit(12'h3C4, 32'h0, "R8 counters untouched");

    // R10: read in same cycle as write returns pre-edge value
    step(1, 12'h384, 32'h77, 1, 0, "R10 read before write");
    rdLit(12'h384, 32'h77, "R10 next read");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic        we, re;
      logic [11:0] a;
      logic [31:0] d;
      we = ($urandom % 8) == 0;
      re = ($urandom % 2) == 0;
      a  = addrPick($urandom % 16);
      d  = ($urandom % 3 == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
      if (we && a == 12'h010 && ($urandom % 4 != 0)) d[1] = 1'b1;
      step(we, a, d, re, 8'($urandom), "R1 R2 R3 R4 R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule